// File: doc/BRIEF.md
# Decision-Feedback Equalizer with Recursive Tail Cancellation

This block equalizes a stream of signed converter samples taken from a smooth channel, one whose interference after the main cursor fades roughly exponentially. It makes a binary decision on each sample, then feeds those decisions back to take the interference they leave on later samples out of the incoming samples. The interference from the previous symbol is removed by a single weighted feedback tap. Everything from two symbols back onward is removed by one first-order recursive low-pass filter that is fed by the decisions, so one small filter takes the place of a long row of feedback taps.

The recursive term follows `t_k = floor(alpha * t_(k-1) / 256) + A * d_(k-2)`, where `alpha` is a decay fraction in steps of 1/256 and `A` is the tail amplitude. The equalized value `z_k = y_k - w1 * d_(k-1) - t_k` is sliced to a decision. All weights are inputs and are used with the sample they arrive with. Training of the weights is left to logic outside the block.

Top module: `dfe_iir_eq`

## Requirements
- R1: Reset clears the tail state to 0, sets both remembered decisions to +1, drives `valid_o` low, `dec_o` high and `eq_o` to 0.
- R2: `valid_o` is high in exactly the cycle after a cycle in which `in_valid_i` was high; one accepted sample yields its result one clock later.
- R3: `dec_o` = 1 encodes a decision of +1 and `dec_o` = 0 encodes -1; the decision is +1 when the equalized value is zero or positive and -1 when it is negative.
- R4: The first feedback tap subtracts `tap1_i` times the decision made on the previous accepted sample (+1 right after reset).
- R5: The tail state updates once per accepted sample to `floor(tail_decay_i * t_prev / 256) + tail_amp_i * d`, with `tail_decay_i` unsigned and rounding of the product toward minus infinity.
- R6: The decision `d` that drives the tail is the one made two accepted samples earlier, so the first two samples after reset use +1, and the third uses the first sample's decision.
- R7: The tail state is held inside the signed range of TAIL_W bits (-2048 to 2047 at default widths) by saturation, never by wrap-around.
- R8: `eq_o` carries `sample_i - tap1_i * d_(k-1) - t_k` exactly, in OUT_W = TAIL_W + 2 signed bits.
- R9: A cycle with `in_valid_i` low changes neither the tail state nor the remembered decisions, and `dec_o` and `eq_o` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Sample strobe |
| sample_i | input | SAMPLE_W | Signed converter sample |
| tap1_i | input | W1_W | Signed weight of the first feedback tap |
| tail_amp_i | input | AMP_W | Signed amplitude of the tail filter |
| tail_decay_i | input | ALPHA_W | Unsigned decay fraction, value/256 |
| valid_o | output | 1 | Result strobe |
| dec_o | output | 1 | Decision, 1 for +1, 0 for -1 |
| eq_o | output | OUT_W | Signed equalized value |

## Verification
Every result belongs to the sample accepted on the previous edge: inputs are driven at a falling edge, registered on the next rising edge, and `valid_o`, `dec_o` and `eq_o` are compared at the following falling edge, exactly one clock after the stimulus. The tail and both remembered decisions move only on accepted samples, so the bench's arithmetic model advances only on steps with the strobe high and, on idle steps, expects the outputs of the previous accepted sample. The effect of a decision on the tail appears two accepted samples later, which directed sequences after reset check at each of those samples.

// File: rtl/dfe_pkg.sv
package dfe_pkg;
    // Decision encoding shared by the equalizer and its checker.
    typedef logic dec_t;
    localparam dec_t DEC_PLUS  = 1'b1;
    localparam dec_t DEC_MINUS = 1'b0;
endpackage

// File: rtl/dfe_tail_iir.sv
// First-order recursive tail estimate: decayed old state plus the
// amplitude signed by the decision two symbols back, then saturated.
module dfe_tail_iir #(
    parameter int ALPHA_W = 8,
    parameter int AMP_W   = 8,
    parameter int TAIL_W  = 12
) (
    input  logic signed [TAIL_W-1:0]  tail_q_i,
    input  logic        [ALPHA_W-1:0] decay_i,
    input  logic signed [AMP_W-1:0]   amp_i,
    input  dfe_pkg::dec_t             dec_old_i,
    output logic signed [TAIL_W-1:0]  tail_d_o
);
    localparam int PROD_W = TAIL_W + ALPHA_W + 2;
    localparam logic signed [PROD_W-1:0] T_MAX =
        {{(PROD_W-TAIL_W+1){1'b0}}, {(TAIL_W-1){1'b1}}};
    localparam logic signed [PROD_W-1:0] T_MIN =
        {{(PROD_W-TAIL_W+1){1'b1}}, {(TAIL_W-1){1'b0}}};

    logic signed [PROD_W-1:0] tail_ext;
    logic signed [PROD_W-1:0] decay_ext;
    logic signed [PROD_W-1:0] amp_ext;
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] decayed;
    logic signed [PROD_W-1:0] amp_term;
    logic signed [PROD_W-1:0] sum;

    always_comb begin
        tail_ext  = {{(PROD_W-TAIL_W){tail_q_i[TAIL_W-1]}}, tail_q_i};
        decay_ext = {{(PROD_W-ALPHA_W){1'b0}}, decay_i};
        amp_ext   = {{(PROD_W-AMP_W){amp_i[AMP_W-1]}}, amp_i};
        prod      = tail_ext * decay_ext;
        decayed   = prod >>> ALPHA_W;
        amp_term  = (dec_old_i == dfe_pkg::DEC_PLUS) ? amp_ext : -amp_ext;
        sum       = decayed + amp_term;
        if (sum > T_MAX) begin
            tail_d_o = T_MAX[TAIL_W-1:0];
        end else if (sum < T_MIN) begin
            tail_d_o = T_MIN[TAIL_W-1:0];
        end else begin
            tail_d_o = sum[TAIL_W-1:0];
        end
    end
endmodule

// File: rtl/dfe_slicer.sv
// Subtracts first-tap and tail interference and slices the result.
module dfe_slicer #(
    parameter int SAMPLE_W = 8,
    parameter int W1_W     = 8,
    parameter int TAIL_W   = 12,
    parameter int OUT_W    = TAIL_W + 2
) (
    input  logic signed [SAMPLE_W-1:0] sample_i,
    input  logic signed [W1_W-1:0]     tap1_i,
    input  dfe_pkg::dec_t              dec_prev_i,
    input  logic signed [TAIL_W-1:0]   tail_i,
    output logic signed [OUT_W-1:0]    eq_o,
    output dfe_pkg::dec_t              dec_o
);
    logic signed [OUT_W-1:0] samp_ext;
    logic signed [OUT_W-1:0] tap_ext;
    logic signed [OUT_W-1:0] tap_term;
    logic signed [OUT_W-1:0] tail_ext;

    always_comb begin
        samp_ext = {{(OUT_W-SAMPLE_W){sample_i[SAMPLE_W-1]}}, sample_i};
        tap_ext  = {{(OUT_W-W1_W){tap1_i[W1_W-1]}}, tap1_i};
        tail_ext = {{(OUT_W-TAIL_W){tail_i[TAIL_W-1]}}, tail_i};
        tap_term = (dec_prev_i == dfe_pkg::DEC_PLUS) ? tap_ext : -tap_ext;
        eq_o     = samp_ext - tap_term - tail_ext;
        dec_o    = eq_o[OUT_W-1] ? dfe_pkg::DEC_MINUS : dfe_pkg::DEC_PLUS;
    end
endmodule

// File: rtl/dfe_iir_eq.sv
// Decision-feedback equalizer: one FIR tap plus a recursive tail filter.
module dfe_iir_eq #(
    parameter int SAMPLE_W = 8,
    parameter int W1_W     = 8,
    parameter int AMP_W    = 8,
    parameter int ALPHA_W  = 8,
    parameter int TAIL_W   = 12,
    parameter int OUT_W    = TAIL_W + 2
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       in_valid_i,
    input  logic signed [SAMPLE_W-1:0] sample_i,
    input  logic signed [W1_W-1:0]     tap1_i,
    input  logic signed [AMP_W-1:0]    tail_amp_i,
    input  logic        [ALPHA_W-1:0]  tail_decay_i,
    output logic                       valid_o,
    output logic                       dec_o,
    output logic signed [OUT_W-1:0]    eq_o
);
    import dfe_pkg::*;

    typedef struct packed {
        logic                     valid;
        dec_t                     dec;   // decision of the last accepted sample
        dec_t                     d2;    // decision one accepted sample before that
        logic signed [OUT_W-1:0]  eq;
        logic signed [TAIL_W-1:0] tail;
    } state_t;

    localparam state_t ST_RESET = '{
        valid: 1'b0,
        dec:   DEC_PLUS,
        d2:    DEC_PLUS,
        eq:    '0,
        tail:  '0
    };

    state_t st_d, st_q;

    logic signed [TAIL_W-1:0] tail_d;
    logic signed [OUT_W-1:0]  eq_d;
    dec_t                     dec_d;

    dfe_tail_iir #(
        .ALPHA_W (ALPHA_W),
        .AMP_W   (AMP_W),
        .TAIL_W  (TAIL_W)
    ) i_tail (
        .tail_q_i  (st_q.tail),
        .decay_i   (tail_decay_i),
        .amp_i     (tail_amp_i),
        .dec_old_i (st_q.d2),
        .tail_d_o  (tail_d)
    );

    dfe_slicer #(
        .SAMPLE_W (SAMPLE_W),
        .W1_W     (W1_W),
        .TAIL_W   (TAIL_W),
        .OUT_W    (OUT_W)
    ) i_slicer (
        .sample_i   (sample_i),
        .tap1_i     (tap1_i),
        .dec_prev_i (st_q.dec),
        .tail_i     (tail_d),
        .eq_o       (eq_d),
        .dec_o      (dec_d)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid_i;
        if (in_valid_i) begin
            st_d.tail = tail_d;
            st_d.eq   = eq_d;
            st_d.d2   = st_q.dec;
            st_d.dec  = dec_d;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= ST_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o = st_q.valid;
    assign dec_o   = st_q.dec;
    assign eq_o    = st_q.eq;
endmodule

// File: rtl/dfe_iir_eq_chk.sv
module dfe_iir_eq_chk #(
    parameter int AMP_W   = 8,
    parameter int ALPHA_W = 8,
    parameter int TAIL_W  = 12,
    parameter int OUT_W   = TAIL_W + 2
) (
    input logic                      clk_i,
    input logic                      rst_ni,
    input logic                      in_valid_i,
    input logic signed [AMP_W-1:0]   tail_amp_i,
    input logic        [ALPHA_W-1:0] tail_decay_i,
    input logic                      valid_o,
    input logic                      dec_o,
    input logic signed [OUT_W-1:0]   eq_o,
    input logic signed [TAIL_W-1:0]  tail_q,
    input logic                      d2_q
);
    logic signed [TAIL_W-1:0] amp_ext;
    logic signed [TAIL_W-1:0] amp_signed;
    assign amp_ext    = {{(TAIL_W-AMP_W){tail_amp_i[AMP_W-1]}}, tail_amp_i};
    assign amp_signed = d2_q ? amp_ext : -amp_ext;

    AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o == $past(in_valid_i)); // R2

    AST_SLICE_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> (dec_o == !eq_o[OUT_W-1])); // R3

    AST_IDLE_HOLD_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(in_valid_i) |-> ($stable(eq_o) && $stable(dec_o))); // R9

    AST_IDLE_HOLD_TAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(in_valid_i) |-> ($stable(tail_q) && $stable(d2_q))); // R9

    AST_DELAY_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(in_valid_i) |-> (d2_q == $past(dec_o))); // R6

    AST_TAIL_NO_DECAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(in_valid_i) && ($past(tail_decay_i) == '0)) |->
            (tail_q == $past(amp_signed))); // R5
endmodule

bind dfe_iir_eq dfe_iir_eq_chk #(
    .AMP_W   (AMP_W),
    .ALPHA_W (ALPHA_W),
    .TAIL_W  (TAIL_W),
    .OUT_W   (OUT_W)
) i_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .in_valid_i   (in_valid_i),
    .tail_amp_i   (tail_amp_i),
    .tail_decay_i (tail_decay_i),
    .valid_o      (valid_o),
    .dec_o        (dec_o),
    .eq_o         (eq_o),
    .tail_q       (st_q.tail),
    .d2_q         (st_q.d2)
);

// File: tb/test_dfe_iir_eq.sv
`timescale 1ns/1ps
module test_dfe_iir_eq;
    logic              clk_i = 1'b0;
    logic              rst_ni = 1'b0;
    logic              in_valid_i = 1'b0;
    logic signed [7:0] sample_i = '0;
    logic signed [7:0] tap1_i = '0;
    logic signed [7:0] tail_amp_i = '0;
    logic        [7:0] tail_decay_i = '0;
    logic              valid_o;
    logic              dec_o;
    logic signed [13:0] eq_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model state
    int m_t, m_d1, m_d2, exp_eq;
    bit exp_dec;

    always #2.5 clk_i = ~clk_i;

    dfe_iir_eq i_dfe_iir_eq (
        .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i),
        .sample_i(sample_i), .tap1_i(tap1_i), .tail_amp_i(tail_amp_i),
        .tail_decay_i(tail_decay_i), .valid_o(valid_o), .dec_o(dec_o),
        .eq_o(eq_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", req, act, expv, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk_i);
        rst_ni = 1'b0;
        in_valid_i = 1'b0;
        @(negedge clk_i);
        @(negedge clk_i);
        rst_ni = 1'b1;
        m_t = 0; m_d1 = 1; m_d2 = 1; exp_eq = 0; exp_dec = 1'b1;
        chk(valid_o == 1'b0, "R1", int'(valid_o), 0);
        chk(dec_o == 1'b1, "R1", int'(dec_o), 1);
        chk(eq_o == '0, "R1", int'(eq_o), 0);
    endtask

    task automatic set_coef(input int w1, input int amp, input int decay);
        tap1_i = 8'(w1);
        tail_amp_i = 8'(amp);
        tail_decay_i = 8'(decay);
    endtask

    // Called at a falling edge; result compared one clock later.
    task automatic step(input bit v, input int y, input string tag);
        int prod;
        in_valid_i = v;
        sample_i = 8'(y);
        if (v) begin
            prod = int'($signed({1'b0, tail_decay_i})) * m_t;
            m_t = (prod >>> 8) + m_d2 * int'(tail_amp_i);
            if (m_t > 2047) m_t = 2047;
            if (m_t < -2048) m_t = -2048;
            exp_eq = y - m_d1 * int'(tap1_i) - m_t;
            exp_dec = (exp_eq >= 0);
            m_d2 = m_d1;
            m_d1 = exp_dec ? 1 : -1;
        end
        @(negedge clk_i);
        chk(valid_o == v, "R2", int'(valid_o), int'(v));
        if (v) begin
            chk(int'(eq_o) == exp_eq, tag, int'(eq_o), exp_eq);
            chk(dec_o == exp_dec, "R3", int'(dec_o), int'(exp_dec));
        end else begin
            chk(int'(eq_o) == exp_eq, "R9", int'(eq_o), exp_eq);
            chk(dec_o == exp_dec, "R9", int'(dec_o), int'(exp_dec));
        end
    endtask

    initial begin
        int cw1[6]   = '{ 20, -35,   0,  60, 127, -128};
        int camp[6]  = '{ 15,  40, -50,   0, -128, 127};
        int cdec[6]  = '{200, 128, 255,  64, 230,  17};
        do_reset();

        // R4: first tap alone, previous decision +1 after reset
        set_coef(40, 0, 0);
        step(1'b1, 0, "R4");
        chk(int'(eq_o) == -40, "R4", int'(eq_o), -40);
        step(1'b1, 30, "R4");              // 30 + 40 = 70 since last dec -1
        chk(int'(eq_o) == 70, "R4", int'(eq_o), 70);

        // R6: tail sign from two samples back
        do_reset();
        set_coef(0, 30, 0);
        step(1'b1, 10, "R6");
        chk(int'(eq_o) == -20, "R6", int'(eq_o), -20);
        step(1'b1, -100, "R6");
        chk(int'(eq_o) == -130, "R6", int'(eq_o), -130);
        step(1'b1, 0, "R6");               // uses first decision (-1): +30
        chk(int'(eq_o) == 30, "R6", int'(eq_o), 30);
        step(1'b1, 0, "R6");               // uses second decision (-1)
        chk(int'(eq_o) == 30, "R6", int'(eq_o), 30);

        // R5: decay arithmetic with floor
        do_reset();
        set_coef(0, 64, 128);
        for (int i = 0; i < 12; i++) step(1'b1, 100, "R5");
        set_coef(0, -7, 191);
        for (int i = 0; i < 12; i++) step(1'b1, (i * 37) % 200 - 100, "R5");

        // R9: idle gaps keep everything
        step(1'b0, 99, "R9");
        step(1'b0, -99, "R9");
        step(1'b1, 5, "R9");

        // R7: saturation at the negative limit
        do_reset();
        set_coef(0, -128, 255);
        for (int i = 0; i < 40; i++) step(1'b1, 0, "R7");
        chk(int'(eq_o) == 2048, "R7", int'(eq_o), 2048);

        // R8 sweep: all sample values under several weight sets, with gaps
        for (int c = 0; c < 6; c++) begin
            do_reset();
            set_coef(cw1[c], camp[c], cdec[c]);
            for (int i = 0; i < 256; i++) begin
                step(1'b1, ((i * 73 + c * 11) % 256) - 128, "R8");
                if (i % 16 == 15) step(1'b0, i, "R9");
            end
        end

        // R1: reset in mid-run restores the start state
        set_coef(25, 50, 100);
        for (int i = 0; i < 5; i++) step(1'b1, 60 - i * 30, "R8");
        do_reset();
        step(1'b1, 0, "R1");
        chk(int'(eq_o) == -75, "R1", int'(eq_o), -75);

        in_valid_i = 1'b0;
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule